// File: doc/BRIEF.md
# Connection Memory Block Access Controller

This block gives a processor access to the connection memory of a time-slot switching matrix. The memory has one entry per output slot: 8 output multiplexes of 32 slots each, 256 entries. Each entry names the input multiplex and input slot that feed that output slot. The processor reaches the memory only through four registers on a simple strobe bus. Those registers are a destination (output multiplex and slot), a source, a data register and a control register. A write to the control register starts an operation.

Some operations touch one entry. These are a single write of the source register, a single read into the data register, and a single transparent write, which maps an output slot to the input slot with the same number. Other operations are automatic bursts that write one entry per clock. A burst can fill from the destination slot to the end of its multiplex, or it can fill the whole memory. The value written is either the data register or an identity mapping. In a cyclic read, each processor read of the data register fetches the next slot of the multiplex.

Top module: `cm_access_ctrl`

## Requirements
- R1: Synchronous active-high reset clears every register, every memory entry, busy and done. Register addresses: 0 destination, 1 source, 2 data, 3 control/status. In all three location registers and in each memory entry, bits [7:5] hold the multiplex and bits [4:0] hold the slot. Control write bits: [0] read, [1] limited cyclic, [2] full cyclic, [3] transparent. A status read returns the last control bits in [3:0], busy in [4] and cyclic-read-active in [5].
- R2: Control value 0 writes the source register into the entry addressed by the destination register.
- R3: A control write with read=1 and limited=0 loads the entry at the destination into the data register, and leaves the memory unchanged.
- R4: Read=0, limited=1, full=0 and transparent=0 writes the data register into every slot from the destination slot to slot 31 of the destination multiplex. No other entry changes.
- R5: A burst raises busy on the cycle after the control write. Busy stays high for exactly one cycle per location written. Done is a single-cycle pulse on the first cycle with busy low again.
- R6: While busy is high, bus writes to any register are ignored, and a control write starts no operation.
- R7: Read=1 with limited=1 loads the destination entry into the data register. Each later read of address 2 then loads the next slot, up to slot 31. After slot 31 has been loaded, further reads leave the data register unchanged and status bit 5 clears.
- R8: Transparent=1 with the other bits clear writes the destination value into the destination entry. The source register is ignored.
- R9: Transparent=1 with limited=1 writes the identity value (each entry's own location) from the destination slot to slot 31 of that multiplex.
- R10: Transparent=1 with full=1 writes the identity value into all 256 entries, one per cycle, starting at location 0.
- R11: Full=1 with transparent=0 and read=0 writes the data register into all 256 entries.
- R12: Read=1 overrides transparent and full, and no memory write occurs. When limited and full are both set with read=0, the full burst is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (advances a cyclic read at address 2) |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the addressed register |
| busy | output | 1 | Automatic burst in progress |
| done | output | 1 | One-cycle pulse after a burst's last write |

## Verification
The bench goes after burst ends that sit on slot boundaries:
- A limited burst started at slot 31 must write exactly one entry. An off-by-one end test would spill into the next multiplex or wrap inside the current one.
- A limited burst from slot 20 must leave slot 19 and the next multiplex untouched.

A cyclic read is run through the last slot. This exposes a pointer that wraps to slot 0 or keeps advancing. Register writes are issued in the middle of a 256-entry fill to catch a design that lets them slip into the burst. A transparent read and a combined limited-plus-full request check the control precedence, which a careless decoder would turn into a stray write or a short burst. Sweeping all 256 entries after each fill catches identity values built from the wrong fields.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

    localparam int MUX_W    = 3;
    localparam int SLOT_W   = 5;
    localparam int LOC_W    = MUX_W + SLOT_W;
    localparam int NUM_LOC  = 1 << LOC_W;
    localparam int BUS_W    = 16;
    localparam int RA_W     = 2;
    localparam int CTRL_W   = 4;

    typedef struct packed {
        logic [MUX_W-1:0]  mux;
        logic [SLOT_W-1:0] slot;
    } loc_t;

    typedef struct packed {
        logic trans;
        logic full;
        logic lim;
        logic rd;
    } ctrl_t;

    typedef enum logic [2:0] {
        OP_WR_ONE,
        OP_RD_ONE,
        OP_RD_CYC,
        OP_FILL_MUX,
        OP_FILL_ALL
    } op_e;

    localparam logic [RA_W-1:0] A_DEST = 2'd0;
    localparam logic [RA_W-1:0] A_SRC  = 2'd1;
    localparam logic [RA_W-1:0] A_DATA = 2'd2;
    localparam logic [RA_W-1:0] A_CTRL = 2'd3;

    // read wins over everything; full wins over limited
    function automatic op_e decode_op(input ctrl_t c);
        if (c.rd)        return c.lim ? OP_RD_CYC : OP_RD_ONE;
        else if (c.full) return OP_FILL_ALL;
        else if (c.lim)  return OP_FILL_MUX;
        else             return OP_WR_ONE;
    endfunction

    function automatic loc_t mux_last(input loc_t l);
        loc_t r;
        r.mux  = l.mux;
        r.slot = '1;
        return r;
    endfunction

    function automatic loc_t next_loc(input loc_t l);
        return loc_t'(LOC_W'(l) + LOC_W'(1));
    endfunction

endpackage

// File: rtl/cmac_store.sv
module cmac_store
    import cmac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  loc_t waddr,
    input  loc_t wdata,
    input  loc_t raddr,
    output loc_t rdata
);
    loc_t mem_q [NUM_LOC];

    for (genvar i = 0; i < NUM_LOC; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                mem_q[i] <= '0;
            else if (we && (LOC_W'(waddr) == LOC_W'(i)))
                mem_q[i] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/cmac_seq.sv
module cmac_seq
    import cmac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  op_e  op,
    input  logic trans,
    input  loc_t base,
    input  loc_t fill,
    output logic busy,
    output logic done,
    output logic we,
    output loc_t waddr,
    output loc_t wdata
);
    logic act_q, done_q, trans_q;
    loc_t ptr_q, last_q, fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            done_q  <= 1'b0;
            trans_q <= 1'b0;
            ptr_q   <= '0;
            last_q  <= '0;
            fill_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                act_q   <= 1'b1;
                trans_q <= trans;
                fill_q  <= fill;
                if (op == OP_FILL_ALL) begin
                    ptr_q  <= '0;
                    last_q <= '1;
                end else begin
                    ptr_q  <= base;
                    last_q <= mux_last(base);
                end
            end else if (act_q) begin
                if (ptr_q == last_q) begin
                    act_q  <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    ptr_q <= next_loc(ptr_q);
                end
            end
        end
    end

    assign busy  = act_q;
    assign done  = done_q;
    assign we    = act_q;
    assign waddr = ptr_q;
    assign wdata = trans_q ? ptr_q : fill_q;
endmodule

// File: rtl/cmac_regs.sv
module cmac_regs
    import cmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [RA_W-1:0]  addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic             busy,
    input  loc_t             mem_rdata,
    output loc_t             mem_raddr,
    output logic             start,
    output op_e              op,
    output logic             trans,
    output loc_t             dest,
    output loc_t             data,
    output logic             one_we,
    output loc_t             one_addr,
    output loc_t             one_data
);
    loc_t  dest_q, src_q, data_q, cyc_ptr_q;
    ctrl_t ctrl_q, ctrl_in;
    logic  cyc_act_q;
    logic  wr_ok, ctrl_wr, cyc_step;
    op_e   op_now;

    assign wr_ok    = wr_en && !busy;
    assign ctrl_wr  = wr_ok && (addr == A_CTRL);
    assign ctrl_in  = ctrl_t'(wdata[CTRL_W-1:0]);
    assign op_now   = decode_op(ctrl_in);
    assign cyc_step = rd_en && (addr == A_DATA) && cyc_act_q && !ctrl_wr;

    assign start    = ctrl_wr && (op_now == OP_FILL_MUX || op_now == OP_FILL_ALL);
    assign op       = op_now;
    assign trans    = ctrl_in.trans;
    assign dest     = dest_q;
    assign data     = data_q;
    assign one_we   = ctrl_wr && (op_now == OP_WR_ONE);
    assign one_addr = dest_q;
    assign one_data = ctrl_in.trans ? dest_q : src_q;
    assign mem_raddr = ctrl_wr ? dest_q : cyc_ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dest_q    <= '0;
            src_q     <= '0;
            data_q    <= '0;
            ctrl_q    <= '0;
            cyc_ptr_q <= '0;
            cyc_act_q <= 1'b0;
        end else begin
            if (wr_ok && addr == A_DEST) dest_q <= loc_t'(wdata[LOC_W-1:0]);
            if (wr_ok && addr == A_SRC)  src_q  <= loc_t'(wdata[LOC_W-1:0]);
            if (wr_ok && addr == A_DATA) data_q <= loc_t'(wdata[LOC_W-1:0]);
            if (ctrl_wr) begin
                ctrl_q    <= ctrl_in;
                cyc_ptr_q <= next_loc(dest_q);
                cyc_act_q <= (op_now == OP_RD_CYC) && (dest_q.slot != '1);
                if (op_now == OP_RD_ONE || op_now == OP_RD_CYC)
                    data_q <= mem_rdata;
            end else if (cyc_step) begin
                data_q    <= mem_rdata;
                cyc_act_q <= (cyc_ptr_q.slot != '1);
                cyc_ptr_q <= next_loc(cyc_ptr_q);
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_DEST: rdata[LOC_W-1:0] = dest_q;
            A_SRC:  rdata[LOC_W-1:0] = src_q;
            A_DATA: rdata[LOC_W-1:0] = data_q;
            A_CTRL: rdata[CTRL_W+1:0] = {cyc_act_q, busy, ctrl_q};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/cm_access_ctrl.sv
module cm_access_ctrl
    import cmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [RA_W-1:0]  addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             busy,
    output logic             done
);
    loc_t mem_rdata, mem_raddr, dest_q, data_q;
    loc_t one_addr, one_data, seq_waddr, seq_wdata, mem_waddr, mem_wdata;
    logic seq_start, seq_trans, one_we, seq_we, mem_we;
    op_e  seq_op;

    cmac_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy(busy), .mem_rdata(mem_rdata),
        .mem_raddr(mem_raddr), .start(seq_start), .op(seq_op), .trans(seq_trans),
        .dest(dest_q), .data(data_q), .one_we(one_we), .one_addr(one_addr),
        .one_data(one_data)
    );

    cmac_seq u_seq (
        .clk(clk), .rst(rst), .start(seq_start), .op(seq_op), .trans(seq_trans),
        .base(dest_q), .fill(data_q), .busy(busy), .done(done),
        .we(seq_we), .waddr(seq_waddr), .wdata(seq_wdata)
    );

    // single writes only start while idle, so the two sources never collide
    assign mem_we    = seq_we | one_we;
    assign mem_waddr = seq_we ? seq_waddr : one_addr;
    assign mem_wdata = seq_we ? seq_wdata : one_data;

    cmac_store u_store (
        .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );
endmodule

// File: rtl/cm_access_ctrl_chk.sv
module cm_access_ctrl_chk
    import cmac_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             busy,
    input logic             done,
    input logic             start,
    input logic             mem_we,
    input logic [LOC_W-1:0] mem_waddr,
    input logic [LOC_W-1:0] dest_q
);
    logic [LOC_W:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    a_r1_reset_idle: assert property (@(posedge clk) $past(rst) |-> (!busy && !done));

    a_r5_done_follows_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && mem_we && $past(mem_we))
            |-> (mem_waddr == LOC_W'($past(mem_waddr) + 1'b1)));

    a_r6_dest_held: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> $stable(dest_q));

    a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    a_r10_busy_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < (LOC_W+1)'(NUM_LOC)));
endmodule

bind cm_access_ctrl cm_access_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .busy(busy), .done(done),
    .start(seq_start), .mem_we(mem_we), .mem_waddr(mem_waddr), .dest_q(dest_q)
);

// File: tb/cm_access_ctrl_tb.sv
`timescale 1ns/1ps
module cm_access_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy, done;

    int checks = 0, errors = 0;
    logic [7:0] model [0:255];

    always #4 clk = ~clk;

    cm_access_ctrl u_dut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy), .done(done));

    localparam int NV = 8;
    localparam logic [7:0] V_DEST [0:NV-1] = '{8'h00, 8'h1F, 8'h20, 8'h5A, 8'h81, 8'hC3, 8'hE0, 8'hFF};
    localparam logic [7:0] V_SRC  [0:NV-1] = '{8'hFF, 8'h01, 8'hA5, 8'h3C, 8'h7E, 8'h00, 8'h99, 8'h42};

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [7:0] loc, output logic [7:0] v);
        logic [15:0] t;
        bus_wr(2'd0, {8'h00, loc});
        bus_wr(2'd3, 16'h0001);
        bus_rd(2'd2, t);
        v = t[7:0];
    endtask

    task automatic check_all(input string req);
        int bad = 0;
        logic [7:0] v;
        for (int i = 0; i < 256; i++) begin
            peek(8'(i), v);
            if (v !== model[i]) begin
                if (bad == 0)
                    $display("FAIL %s: entry %0h actual=%h expected=%h", req, i, v, model[i]);
                bad++;
            end
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    task automatic wait_burst(input string req, input int len);
        int n = 0;
        chk({req, " busy raised"}, 16'(busy), 16'h1);
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk({req, " burst length"}, 16'(n), 16'(len));
        chk({req, " done pulse"}, 16'(done), 16'h1);
        @(negedge clk);
        chk({req, " done cleared"}, 16'(done), 16'h0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] r;
        logic [7:0] v;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            bus_rd(2'(a), r);
            chk("R1 register reset", r, 16'h0000);
        end
        chk("R1 busy reset", 16'(busy), 16'h0);
        chk("R1 done reset", 16'(done), 16'h0);
        check_all("R1 memory reset");

        // R2 / R3 vector table: single write then single read back
        for (int i = 0; i < NV; i++) begin
            bus_wr(2'd0, {8'h00, V_DEST[i]});
            bus_wr(2'd1, {8'h00, V_SRC[i]});
            bus_wr(2'd3, 16'h0000);
            chk("R2 single write not busy", 16'(busy), 16'h0);
            model[V_DEST[i]] = V_SRC[i];
            peek(V_DEST[i], v);
            chk("R2 R3 single write/read", 16'(v), 16'(V_SRC[i]));
        end
        check_all("R3 memory after reads");

        // R8 transparent single, source ignored
        bus_wr(2'd0, 16'h0047);
        bus_wr(2'd1, 16'h00AA);
        bus_wr(2'd3, 16'h0008);
        chk("R8 no burst", 16'(busy), 16'h0);
        model[8'h47] = 8'h47;
        peek(8'h47, v);
        chk("R8 transparent single", 16'(v), 16'h0047);

        // R4 / R5 limited burst from mux 3 slot 20
        bus_wr(2'd2, 16'h003C);
        bus_wr(2'd0, 16'h0074);
        bus_wr(2'd3, 16'h0002);
        wait_burst("R5 limited burst", 12);
        for (int i = 8'h74; i <= 8'h7F; i++) model[i] = 8'h3C;
        check_all("R4 limited fill");

        // R5 burst started at slot 31 writes one entry
        bus_wr(2'd2, 16'h0099);
        bus_wr(2'd0, 16'h001F);
        bus_wr(2'd3, 16'h0002);
        wait_burst("R5 slot31 burst", 1);
        model[8'h1F] = 8'h99;
        peek(8'h1F, v);
        chk("R4 slot31 entry", 16'(v), 16'h0099);
        peek(8'h20, v);
        chk("R4 next mux untouched", 16'(v), 16'(model[8'h20]));

        // R9 transparent limited over mux 5
        bus_wr(2'd0, 16'h00A0);
        bus_wr(2'd3, 16'h000A);
        wait_burst("R9 transparent mux", 32);
        for (int i = 8'hA0; i <= 8'hBF; i++) model[i] = 8'(i);
        check_all("R9 identity mux fill");

        // R7 cyclic read from mux 5 slot 29
        bus_wr(2'd0, 16'h00BD);
        bus_wr(2'd3, 16'h0003);
        bus_rd(2'd3, r);
        chk("R7 cyclic active flag", r & 16'h0020, 16'h0020);
        bus_rd(2'd2, r); chk("R7 cyclic read 1", r, 16'h00BD);
        bus_rd(2'd2, r); chk("R7 cyclic read 2", r, 16'h00BE);
        bus_rd(2'd2, r); chk("R7 cyclic read 3", r, 16'h00BF);
        bus_rd(2'd2, r); chk("R7 cyclic stops at slot 31", r, 16'h00BF);
        bus_rd(2'd3, r);
        chk("R7 cyclic flag cleared", r & 16'h0020, 16'h0000);

        // R12 transparent + read acts as a read only
        bus_wr(2'd0, 16'h0074);
        bus_wr(2'd1, 16'h0011);
        bus_wr(2'd3, 16'h0009);
        chk("R12 read no burst", 16'(busy), 16'h0);
        bus_rd(2'd2, r);
        chk("R12 read over transparent", r, 16'h003C);
        peek(8'h74, v);
        chk("R12 entry unchanged", 16'(v), 16'h003C);

        // R11 full fill with R6 writes during busy
        bus_wr(2'd0, 16'h0012);
        bus_wr(2'd1, 16'h0034);
        bus_wr(2'd2, 16'h005A);
        bus_wr(2'd3, 16'h0004);
        chk("R11 busy after start", 16'(busy), 16'h1);
        bus_wr(2'd0, 16'h0033);
        bus_wr(2'd1, 16'h0044);
        bus_wr(2'd2, 16'h0077);
        bus_wr(2'd3, 16'h0000);
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R6 no restart", 16'(busy), 16'h0);
        bus_rd(2'd0, r); chk("R6 dest held", r, 16'h0012);
        bus_rd(2'd1, r); chk("R6 src held", r, 16'h0034);
        bus_rd(2'd2, r); chk("R6 data held", r, 16'h005A);
        bus_rd(2'd3, r); chk("R6 control held", r & 16'h000F, 16'h0004);
        for (int i = 0; i < 256; i++) model[i] = 8'h5A;
        check_all("R11 full data fill");

        // R10 + R12 transparent with limited and full: full burst wins
        bus_wr(2'd0, 16'h0065);
        bus_wr(2'd3, 16'h000E);
        wait_burst("R10 R12 full identity", 256);
        for (int i = 0; i < 256; i++) model[i] = 8'(i);
        check_all("R10 identity everywhere");

        // R1 reset in the middle of a burst
        bus_wr(2'd2, 16'h00C1);
        bus_wr(2'd3, 16'h0004);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 busy cleared by reset", 16'(busy), 16'h0);
        bus_rd(2'd2, r); chk("R1 data cleared by reset", r, 16'h0000);
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        check_all("R1 memory cleared by reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule